// File: doc/BRIEF.md
# DMA Bus Request and Interrupt Holdoff

This block sits between one DMA channel and the system bus controller. A request pulse from the channel is captured and turned into a bus request. When the controller grants the bus, the block lets the channel run transfer cycles. While it is requesting or holding the bus, it tells the CPU to hold off ordinary interrupts. This includes an interrupt that is already being serviced, which is suspended.

Two kinds of interrupt can preempt the DMA: a non-maskable interrupt, or a maskable one whose 5-bit level beats a programmable override level. A smaller number means higher priority, and the comparison is strict. When one of these is present, the block withdraws its bus request at the next transfer boundary. It keeps the unfinished work and asks for the bus again on its own once the preempting source goes away.

The controller is a Moore state machine with five states:
- IDLE: nothing is pending.
- REQUEST: the bus is requested and the block waits for a grant.
- TRANSFER: the bus is held and cycles run.
- PAUSE: the request is withdrawn because of a preempting interrupt.
- DONE: a one-cycle completion state.

The transitions are:
- IDLE→REQUEST on a pending request.
- REQUEST→TRANSFER on a grant.
- REQUEST→PAUSE on preemption.
- TRANSFER→DONE on a boundary that is marked last.
- TRANSFER→PAUSE on a boundary with preemption.
- PAUSE→REQUEST when preemption clears.
- DONE→IDLE unconditionally.

Top module: `dma_bus_holdoff`

## Requirements
- R1: After reset, bus_req_o, xfer_go_o, irq_hold_o and done_o are all 0 (state IDLE).
- R2: A request pulse on req_pulse_i in IDLE raises bus_req_o on the next cycle. xfer_go_o stays 0 until bus_grant_i is seen high, and it rises on the cycle after that grant.
- R3: irq_hold_o is 1 exactly in REQUEST and TRANSFER. It is 0 in IDLE, PAUSE and DONE.
- R4: In TRANSFER, a boundary (cycle_done_i=1, last_i=0) with nmi_i=1 enters PAUSE. On the next cycle bus_req_o, xfer_go_o and irq_hold_o are all 0.
- R5: Without cycle_done_i, TRANSFER is never left, even when a preempting interrupt is present. bus_req_o stays 1.
- R6: A maskable interrupt (irq_valid_i=1) preempts only when irq_level_i < hold_lvl_i, compared as unsigned numbers. A level equal to or above hold_lvl_i has no effect on the request.
- R7: PAUSE is held while the preempting source persists. Once it is gone, bus_req_o is 1 on the next cycle, and xfer_go_o follows one cycle after a new grant.
- R8: A boundary with last_i=1 enters DONE, even when preemption is present. done_o is 1 for exactly one cycle with bus_req_o at 0, and the block then returns to IDLE.
- R9: A request that arrives while a non-preempting interrupt is active is accepted. bus_req_o and irq_hold_o go to 1.
- R10: Preemption seen in REQUEST, where no cycle is in progress, enters PAUSE on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse_i | input | 1 | Channel transfer request pulse |
| bus_grant_i | input | 1 | Grant from bus controller |
| cycle_done_i | input | 1 | Transfer boundary from channel |
| last_i | input | 1 | Boundary is the final one |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| irq_valid_i | input | 1 | Maskable interrupt pending |
| irq_level_i | input | 5 | Pending interrupt level, smaller is higher |
| hold_lvl_i | input | 5 | Hold-override level |
| bus_req_o | output | 1 | Bus request to controller |
| xfer_go_o | output | 1 | Channel may run transfer cycles |
| irq_hold_o | output | 1 | Hold off ordinary interrupts at the CPU |
| done_o | output | 1 | One-cycle completion indication |

## Verification
Every output is decoded from the state register alone, so the response to any stimulus is due exactly one clock edge after the inputs are applied. A grant that is applied while in REQUEST shows up on xfer_go_o one edge later. Preemption on a boundary clears bus_req_o one edge later.

The driver applies inputs on the falling edge and queues the outputs it expects after the next rising edge. The monitor checks them shortly after that edge, so each check lands on the single cycle where the result is due. Multi-step behaviour is checked one step at a time, with one queued expectation per cycle:
- waiting without a grant;
- the pause being held;
- the return to IDLE after DONE.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQUEST  = 3'd1,
        ST_TRANSFER = 3'd2,
        ST_PAUSE    = 3'd3,
        ST_DONE     = 3'd4
    } hold_state_e;
endpackage

// File: rtl/dma_preempt_cmp.sv
module dma_preempt_cmp #(
    parameter int LVL_W = 5
) (
    input  logic             nmi_i,
    input  logic             irq_valid_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] hold_lvl_i,
    output logic             preempt_o
);
    // smaller level value means higher priority; strictly above threshold preempts
    always_comb begin
        preempt_o = nmi_i | (irq_valid_i & (irq_level_i < hold_lvl_i));
    end
endmodule

// File: rtl/dma_hold_fsm.sv
module dma_hold_fsm
    import dma_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_pulse_i,
    input  logic bus_grant_i,
    input  logic cycle_done_i,
    input  logic last_i,
    input  logic preempt_i,
    output logic bus_req_o,
    output logic xfer_go_o,
    output logic irq_hold_o,
    output logic done_o
);
    hold_state_e state_q, state_d;
    logic        pend_q, pend_d;
    logic        finish;

    assign finish = (state_q == ST_TRANSFER) & cycle_done_i & last_i;

    // pending work is kept until the final boundary
    always_comb begin
        pend_d = req_pulse_i | (pend_q & ~finish);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (pend_q || req_pulse_i) state_d = ST_REQUEST;
            ST_REQUEST:  if (preempt_i)             state_d = ST_PAUSE;
                         else if (bus_grant_i)      state_d = ST_TRANSFER;
            ST_TRANSFER: if (cycle_done_i) begin
                             if (last_i)            state_d = ST_DONE;
                             else if (preempt_i)    state_d = ST_PAUSE;
                         end
            ST_PAUSE:    if (!preempt_i)            state_d = ST_REQUEST;
            ST_DONE:                                state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        bus_req_o  = 1'b0;
        xfer_go_o  = 1'b0;
        irq_hold_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_REQUEST:  begin bus_req_o = 1'b1; irq_hold_o = 1'b1; end
            ST_TRANSFER: begin bus_req_o = 1'b1; irq_hold_o = 1'b1; xfer_go_o = 1'b1; end
            ST_PAUSE:    ;
            ST_DONE:     done_o = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/dma_bus_holdoff.sv
module dma_bus_holdoff #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pulse_i,
    input  logic             bus_grant_i,
    input  logic             cycle_done_i,
    input  logic             last_i,
    input  logic             nmi_i,
    input  logic             irq_valid_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] hold_lvl_i,
    output logic             bus_req_o,
    output logic             xfer_go_o,
    output logic             irq_hold_o,
    output logic             done_o
);
    logic preempt;

    dma_preempt_cmp #(.LVL_W(LVL_W)) cmp_i (
        .nmi_i       (nmi_i),
        .irq_valid_i (irq_valid_i),
        .irq_level_i (irq_level_i),
        .hold_lvl_i  (hold_lvl_i),
        .preempt_o   (preempt)
    );

    dma_hold_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_pulse_i  (req_pulse_i),
        .bus_grant_i  (bus_grant_i),
        .cycle_done_i (cycle_done_i),
        .last_i       (last_i),
        .preempt_i    (preempt),
        .bus_req_o    (bus_req_o),
        .xfer_go_o    (xfer_go_o),
        .irq_hold_o   (irq_hold_o),
        .done_o       (done_o)
    );
endmodule

// File: rtl/dma_bus_holdoff_chk.sv
module dma_bus_holdoff_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_grant_i,
    input logic cycle_done_i,
    input logic last_i,
    input logic nmi_i,
    input logic bus_req_o,
    input logic xfer_go_o,
    input logic irq_hold_o,
    input logic done_o
);
    // R2
    go_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go_o |-> bus_req_o);
    // R2
    go_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_go_o) |-> $past(bus_grant_i));
    // R3
    hold_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> irq_hold_o);
    // R5
    no_midcycle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go_o && !cycle_done_i) |=> bus_req_o);
    // R4
    nmi_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go_o && cycle_done_i && nmi_i && !last_i) |=> (!bus_req_o && !done_o));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind dma_bus_holdoff dma_bus_holdoff_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_grant_i  (bus_grant_i),
    .cycle_done_i (cycle_done_i),
    .last_i       (last_i),
    .nmi_i        (nmi_i),
    .bus_req_o    (bus_req_o),
    .xfer_go_o    (xfer_go_o),
    .irq_hold_o   (irq_hold_o),
    .done_o       (done_o)
);

// File: tb/dma_bus_holdoff_tb_top.sv
`timescale 1ns/1ps
module dma_bus_holdoff_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_pulse, grant, cdone, last, nmi, irqv;
    logic [4:0] lvl, hold_lvl;
    logic bus_req, go, hold, done;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_bus_holdoff dut_i (
        .clk(clk), .rst_n(rst_n), .req_pulse_i(req_pulse), .bus_grant_i(grant),
        .cycle_done_i(cdone), .last_i(last), .nmi_i(nmi), .irq_valid_i(irqv),
        .irq_level_i(lvl), .hold_lvl_i(hold_lvl), .bus_req_o(bus_req),
        .xfer_go_o(go), .irq_hold_o(hold), .done_o(done)
    );

    function automatic void compare(logic [3:0] exp, string tag);
        logic [3:0] act;
        act = {bus_req, go, hold, done};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {req,go,hold,done} actual=%b expected=%b", tag, act, exp);
        end
    endfunction

    // driver: apply inputs on falling edge, queue result expected after next rise
    task automatic step(input logic r, g, cd, ls, nm, iv, input logic [4:0] l,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        req_pulse = r; grant = g; cdone = cd; last = ls; nmi = nm; irqv = iv; lvl = l;
        sb_q.push_back('{exp, tag});
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                compare(e.exp, e.tag);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        req_pulse = 0; grant = 0; cdone = 0; last = 0; nmi = 0; irqv = 0;
        lvl = 5'd0; hold_lvl = 5'd10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(4'b0000, "R1 reset state");
        //     req g cd ls nm iv lvl   {req,go,hold,done}
        step(1, 0, 0, 0, 0, 0, 5'd0,  4'b1010, "R2 request raised");
        step(0, 0, 0, 0, 0, 0, 5'd0,  4'b1010, "R2 wait without grant");
        step(0, 1, 0, 0, 0, 0, 5'd0,  4'b1110, "R2 R3 grant starts transfer");
        step(0, 1, 1, 0, 0, 0, 5'd0,  4'b1110, "R8 boundary not last");
        step(0, 1, 1, 0, 0, 1, 5'd20, 4'b1110, "R6 low-priority irq ignored");
        step(0, 1, 1, 0, 0, 1, 5'd10, 4'b1110, "R6 equal level ignored");
        step(0, 1, 0, 0, 0, 1, 5'd5,  4'b1110, "R5 no boundary keeps bus");
        step(0, 1, 1, 0, 0, 1, 5'd5,  4'b0000, "R6 R3 high irq pauses");
        step(0, 0, 0, 0, 0, 1, 5'd5,  4'b0000, "R7 pause held");
        step(0, 0, 0, 0, 0, 0, 5'd0,  4'b1010, "R7 re-request");
        step(0, 1, 0, 0, 0, 0, 5'd0,  4'b1110, "R7 resume after grant");
        step(0, 1, 0, 0, 1, 0, 5'd0,  4'b1110, "R5 nmi mid-cycle");
        step(0, 1, 1, 0, 1, 0, 5'd0,  4'b0000, "R4 nmi at boundary");
        step(0, 0, 0, 0, 1, 0, 5'd0,  4'b0000, "R4 pause while nmi");
        step(0, 1, 0, 0, 0, 0, 5'd0,  4'b1010, "R7 nmi cleared");
        step(0, 1, 0, 0, 0, 0, 5'd0,  4'b1110, "R7 transfer again");
        step(0, 1, 1, 1, 0, 0, 5'd0,  4'b0001, "R8 R3 done");
        step(0, 0, 0, 0, 0, 0, 5'd0,  4'b0000, "R8 back to idle");
        step(1, 0, 0, 0, 0, 1, 5'd20, 4'b1010, "R9 accepted during irq");
        step(0, 0, 0, 0, 0, 1, 5'd20, 4'b1010, "R9 holds irq");
        step(0, 0, 0, 0, 1, 0, 5'd0,  4'b0000, "R10 preempt in request");
        step(0, 0, 0, 0, 0, 0, 5'd0,  4'b1010, "R10 re-request");
        step(0, 1, 0, 0, 0, 0, 5'd0,  4'b1110, "R2 transfer");
        step(0, 1, 1, 1, 1, 0, 5'd0,  4'b0001, "R8 last beats preempt");
        step(0, 0, 0, 0, 0, 0, 5'd0,  4'b0000, "R8 idle");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule